// File: doc/BRIEF.md
# Split-Word Host Memory Port

This block gives an external host direct access to a 1024-word by 24-bit memory while the device is in one of its host-access modes. The host presents a 10-bit address, active-low read and write strobes, an upper-half select line and a shared 24-bit data bus, which is modelled here as an input bus, an output bus and a drive enable. The strobes come from outside the system clock domain, so each passes through a two-stage synchroniser before it acts on the memory.

Two access widths are offered. In wide mode every access moves a whole 24-bit word. In narrow mode a 16-bit host reaches a word in two halves. With the select low it uses bits 15:0. With the select high, bits 23:16 of the word travel on bus bits 7:0. A partial write leaves the other half of the word untouched. When host access is switched off, the write strobe does nothing and the bus is never driven. A flash-clear input empties the memory in one clock.

Top module: `split_word_host_port`

## Requirements
- R1: With `hostActive`=1 and `narrowMode`=0, a write stores all of `busIn[23:0]` at `hostAddr`, and a later read of that address returns the full word on `busOut[23:0]`.
- R2: A write commits to memory on the third rising clock edge after `wrN` goes from 0 to 1. A read that starts as `wrN` rises shows the old word after that third edge and the new word after the fourth.
- R3: `busDrive` is 1 exactly when `hostActive`=1, the value of `rdN` sampled two edges earlier is 0, and the value of `wrN` sampled two edges earlier is 1. While `busDrive` is 0, `busOut` is zero.
- R4: With `narrowMode`=1 and `upperSel`=0, a write stores `busIn[15:0]` into word bits 15:0 and leaves bits 23:16 unchanged.
- R5: With `narrowMode`=1 and `upperSel`=1, a write stores `busIn[7:0]` into word bits 23:16 and leaves bits 15:0 unchanged. Bus bits 23:8 are ignored.
- R6: A narrow read with `upperSel`=0 returns {8'h00, word[15:0]}. A narrow read with `upperSel`=1 returns {16'h0000, word[23:16]}. Undriven upper bus bits read as zero.
- R7: In wide mode, `upperSel` has no effect on either writes or reads.
- R8: While `hostActive`=0, a pulse on `wrN` leaves the memory unchanged and `busDrive` stays 0.
- R9: If `clearN` is 0 at a rising edge, every word reads as zero afterwards, and `busOut` is zero on the following cycle.
- R10: After reset, every word reads as zero and `busDrive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostActive | input | 1 | 1 = host-access mode, 0 = processing mode (port idle) |
| narrowMode | input | 1 | 1 = 16-bit split access, 0 = 24-bit access |
| upperSel | input | 1 | Narrow mode: 1 = upper 8-bit half, 0 = lower 16-bit half |
| hostAddr | input | 10 | Word address |
| rdN | input | 1 | Active-low read strobe (asynchronous) |
| wrN | input | 1 | Active-low write strobe (asynchronous) |
| clearN | input | 1 | Active-low flash clear, sampled on the clock |
| busIn | input | 24 | Write data from the shared bus |
| busOut | output | 24 | Read data to the shared bus |
| busDrive | output | 1 | Bus drive enable |

## Verification
A fault in a field bank's fill bits or stored data shows up as a wrong half-word on the very next read of that address. This happens four cycles after `rdN` falls, and the bench catches it because its reference memory is compared with `busOut` on every clock. A synchroniser or edge detector with the wrong depth moves the commit edge or the drive window by a cycle. The per-clock comparison of `busDrive`, and the read that watches the bus across a commit, both expose such a shift at once. Swapping the half-word field routing corrupts the untouched half of a narrow write, and this is visible on the following wide read.

// File: rtl/hwp_pkg.sv
package hwp_pkg;
  // Per-cycle strobes from the control side to the datapath
  typedef struct packed {
    logic commit;   // write the current address this cycle
    logic readOn;   // bus may be driven
    logic clear;    // flash clear this cycle
    logic narrow;   // 16-bit split access
    logic upper;    // upper half selected (narrow only)
  } hwp_strobe_t;
endpackage

// File: rtl/hwp_ctrl.sv
module hwp_ctrl
  import hwp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostActive,
  input  logic        narrowMode,
  input  logic        upperSel,
  input  logic        rdN,
  input  logic        wrN,
  input  logic        clearN,
  output hwp_strobe_t strobe
);
  // write chain carries one extra stage used as the edge reference
  localparam int WR_LEN = SYNC_STAGES + 1;

  logic [WR_LEN-1:0]      wrChain;
  logic [SYNC_STAGES-1:0] rdChain;
  logic wrSync, wrPrev, rdSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrChain <= '1;
      rdChain <= '1;
    end else begin
      wrChain <= {wrChain[WR_LEN-2:0], wrN};
      rdChain <= {rdChain[SYNC_STAGES-2:0], rdN};
    end
  end

  assign wrSync = wrChain[SYNC_STAGES-1];
  assign wrPrev = wrChain[SYNC_STAGES];
  assign rdSync = rdChain[SYNC_STAGES-1];

  always_comb begin
    strobe.clear  = ~clearN;
    strobe.commit = hostActive & wrSync & ~wrPrev & clearN;
    strobe.readOn = hostActive & ~rdSync & wrSync;
    strobe.narrow = narrowMode;
    strobe.upper  = upperSel;
  end
endmodule

// File: rtl/hwp_field_bank.sv
module hwp_field_bank #(
  parameter int ADDR_W  = 10,
  parameter int FIELD_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clear,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [FIELD_W-1:0] wrData,
  output logic [FIELD_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [FIELD_W-1:0] store [DEPTH];
  logic [DEPTH-1:0]   filled;

  always_ff @(posedge clk) begin
    if (wrEn && !clear) store[addr] <= wrData;
  end

  // a cleared word is marked empty instead of being overwritten
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      filled       <= '0;
    else if (clear) filled       <= '0;
    else if (wrEn)  filled[addr] <= 1'b1;
  end

  assign rdData = filled[addr] ? store[addr] : '0;
endmodule

// File: rtl/hwp_datapath.sv
module hwp_datapath
  import hwp_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 24,
  parameter int LO_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  hwp_strobe_t       strobe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busDrive
);
  localparam int HI_W    = DATA_W - LO_W;
  localparam int NFIELDS = 2;

  logic [DATA_W-1:0] wordNow, readNext, readReg;

  for (genvar g = 0; g < NFIELDS; g++) begin : g_field
    localparam int FW = (g == 0) ? LO_W : HI_W;
    logic          wrEn;
    logic [FW-1:0] wrData, rdData;

    if (g == 0) begin : g_lo
      assign wrEn   = strobe.commit & (~strobe.narrow | ~strobe.upper);
      assign wrData = busIn[LO_W-1:0];
    end else begin : g_hi
      assign wrEn   = strobe.commit & (~strobe.narrow | strobe.upper);
      assign wrData = strobe.narrow ? busIn[HI_W-1:0] : busIn[DATA_W-1:LO_W];
    end

    hwp_field_bank #(.ADDR_W(ADDR_W), .FIELD_W(FW)) u_bank (
      .clk   (clk),
      .rstN  (rstN),
      .clear (strobe.clear),
      .wrEn  (wrEn),
      .addr  (hostAddr),
      .wrData(wrData),
      .rdData(rdData)
    );
  end

  assign wordNow = {g_field[1].rdData, g_field[0].rdData};

  always_comb begin
    if (!strobe.narrow)    readNext = wordNow;
    else if (strobe.upper) readNext = {{LO_W{1'b0}}, wordNow[DATA_W-1:LO_W]};
    else                   readNext = {{HI_W{1'b0}}, wordNow[LO_W-1:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             readReg <= '0;
    else if (strobe.clear) readReg <= '0;
    else                   readReg <= readNext;
  end

  assign busDrive = strobe.readOn;
  assign busOut   = strobe.readOn ? readReg : '0;
endmodule

// File: rtl/split_word_host_port.sv
module split_word_host_port
  import hwp_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 24,
  parameter int LO_W        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostActive,
  input  logic              narrowMode,
  input  logic              upperSel,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              clearN,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busDrive
);
  hwp_strobe_t ctrlStrobe;

  hwp_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostActive(hostActive),
    .narrowMode(narrowMode),
    .upperSel  (upperSel),
    .rdN       (rdN),
    .wrN       (wrN),
    .clearN    (clearN),
    .strobe    (ctrlStrobe)
  );

  hwp_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LO_W(LO_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (ctrlStrobe),
    .hostAddr(hostAddr),
    .busIn   (busIn),
    .busOut  (busOut),
    .busDrive(busDrive)
  );
endmodule

// File: rtl/hwp_checker.sv
module hwp_checker
  import hwp_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int LO_W   = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostActive,
  input logic              narrowMode,
  input logic              upperSel,
  input logic              rdN,
  input logic              wrN,
  input logic              clearN,
  input logic [DATA_W-1:0] busOut,
  input logic              busDrive,
  input hwp_strobe_t       strobe
);
  localparam int HI_W = DATA_W - LO_W;

  // R3
  drive_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    busDrive |-> (!$past(rdN, 2) && $past(wrN, 2) && hostActive));

  // R3
  no_drive_in_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(wrN, 2) |-> !busDrive);

  // R2
  commit_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |-> (!$past(wrN, 3) && $past(wrN, 2)));

  // R6
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busDrive && $past(narrowMode) && $past(upperSel)) |-> (busOut[DATA_W-1:HI_W] == '0));

  // R6
  narrow_lower_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busDrive && $past(narrowMode) && !$past(upperSel)) |-> (busOut[DATA_W-1:LO_W] == '0));

  // R9
  clear_output_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clearN |=> (busOut == '0));
endmodule

bind split_word_host_port hwp_checker #(.DATA_W(DATA_W), .LO_W(LO_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .hostActive(hostActive),
  .narrowMode(narrowMode),
  .upperSel  (upperSel),
  .rdN       (rdN),
  .wrN       (wrN),
  .clearN    (clearN),
  .busOut    (busOut),
  .busDrive  (busDrive),
  .strobe    (ctrlStrobe)
);

// File: tb/sim_split_word_host_port.sv
module sim_split_word_host_port;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostActive = 1'b1;
  logic        narrowMode = 1'b0;
  logic        upperSel = 1'b0;
  logic [9:0]  hostAddr = '0;
  logic        rdN = 1'b1;
  logic        wrN = 1'b1;
  logic        clearN = 1'b1;
  logic [23:0] busIn = '0;
  logic [23:0] busOut;
  logic        busDrive;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  split_word_host_port u0 (
    .clk(clk), .rstN(rstN), .hostActive(hostActive), .narrowMode(narrowMode),
    .upperSel(upperSel), .hostAddr(hostAddr), .rdN(rdN), .wrN(wrN),
    .clearN(clearN), .busIn(busIn), .busOut(busOut), .busDrive(busDrive)
  );

  task automatic check(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: strobe history, word store, read register
  int unsigned refMem [int];
  bit mW1 = 1, mW2 = 1, mWp = 1, mR1 = 1, mR2 = 1;
  int unsigned mRead = 0;

  function automatic int unsigned refWord(input int a);
    return refMem.exists(a) ? refMem[a] : 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mW1 = 1; mW2 = 1; mWp = 1; mR1 = 1; mR2 = 1; mRead = 0;
      refMem.delete();
    end else begin
      bit doWrite;
      int unsigned w, nextRead;
      doWrite = hostActive && mW2 && !mWp;
      w = refWord(hostAddr);
      if (!clearN) nextRead = 0;
      else if (!narrowMode) nextRead = w;
      else if (upperSel) nextRead = (w >> 16) & 32'hFF;
      else nextRead = w & 32'hFFFF;
      if (!clearN) refMem.delete();
      else if (doWrite) begin
        if (!narrowMode) w = busIn;
        else if (upperSel) w = (w & 32'h00FFFF) | ((int'(busIn) & 32'hFF) << 16);
        else w = (w & 32'hFF0000) | (int'(busIn) & 32'hFFFF);
        refMem[hostAddr] = w;
      end
      mRead = nextRead;
      mWp = mW2; mW2 = mW1; mW1 = wrN;
      mR2 = mR1; mR1 = rdN;
    end
  end

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #1;
    if (rstN) begin
      bit expDrive;
      expDrive = hostActive && !mR2 && mW2;
      check(busDrive == expDrive, "R3 drive", {23'd0, busDrive}, {23'd0, expDrive});
      check(busOut == (expDrive ? mRead[23:0] : 24'd0), "R1 model data", busOut,
            expDrive ? mRead[23:0] : 24'd0);
    end
  end

  task automatic hostWrite(input logic [9:0] a, input logic [23:0] d, input bit nar, input bit up);
    @(negedge clk);
    hostAddr = a; busIn = d; narrowMode = nar; upperSel = up; wrN = 0;
    repeat (3) @(negedge clk);
    wrN = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic hostRead(input logic [9:0] a, input bit nar, input bit up,
                          input logic [23:0] exp, input string req);
    @(negedge clk);
    hostAddr = a; narrowMode = nar; upperSel = up; rdN = 0;
    repeat (4) @(negedge clk);
    #2;
    check(busDrive === 1'b1 && busOut === exp, req, busOut, exp);
    @(negedge clk);
    rdN = 1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk); #2;
    // R10: idle after reset
    check(busDrive === 1'b0 && busOut === 24'd0, "R10 reset idle", busOut, 24'd0);
    hostRead(10'd5, 0, 0, 24'h000000, "R10 empty after reset");

    // R1 full-width round trip, including top address
    hostWrite(10'd3, 24'hABCDEF, 0, 0);
    hostRead(10'd3, 0, 0, 24'hABCDEF, "R1 wide read");
    hostWrite(10'h3FF, 24'h5A5A5A, 0, 0);
    hostRead(10'h3FF, 0, 0, 24'h5A5A5A, "R1 top address");

    // R7 select ignored in wide mode
    hostWrite(10'd4, 24'h123456, 0, 1);
    hostRead(10'd4, 0, 1, 24'h123456, "R7 wide with select high");
    hostRead(10'd4, 0, 0, 24'h123456, "R7 wide with select low");

    // R4/R6 narrow lower half
    hostWrite(10'd3, 24'hEE1111, 1, 0);
    hostRead(10'd3, 1, 0, 24'h001111, "R4 R6 narrow lower read");
    hostRead(10'd3, 0, 0, 24'hAB1111, "R4 upper half kept");

    // R5/R6 narrow upper half, bus bits 23:8 ignored
    hostWrite(10'd3, 24'hFFFF77, 1, 1);
    hostRead(10'd3, 1, 1, 24'h000077, "R5 R6 narrow upper read");
    hostRead(10'd3, 0, 0, 24'h771111, "R5 lower half kept");

    // R8 port idle outside host mode
    @(negedge clk); hostActive = 0;
    hostWrite(10'd3, 24'h000000, 0, 0);
    @(negedge clk); rdN = 0;
    repeat (4) @(negedge clk); #2;
    check(busDrive === 1'b0, "R8 no drive when idle", {23'd0, busDrive}, 24'd0);
    @(negedge clk); rdN = 1; hostActive = 1;
    repeat (3) @(negedge clk);
    hostRead(10'd3, 0, 0, 24'h771111, "R8 write ignored");

    // R2 commit timing seen by a read started as wrN rises
    @(negedge clk);
    hostAddr = 10'd4; busIn = 24'h0F0F0F; narrowMode = 0; upperSel = 0; wrN = 0;
    repeat (3) @(negedge clk);
    wrN = 1; rdN = 0;
    repeat (3) @(negedge clk);
    #2;
    check(busDrive === 1'b1 && busOut === 24'h123456, "R2 old word before commit", busOut, 24'h123456);
    @(negedge clk); #2;
    check(busDrive === 1'b1 && busOut === 24'h0F0F0F, "R2 new word after commit", busOut, 24'h0F0F0F);
    @(negedge clk); rdN = 1;
    repeat (3) @(negedge clk);

    // R9 flash clear
    @(negedge clk); clearN = 0;
    @(negedge clk); clearN = 1;
    hostRead(10'd3, 0, 0, 24'h000000, "R9 cleared word");
    hostRead(10'h3FF, 0, 0, 24'h000000, "R9 cleared top word");
    hostWrite(10'd3, 24'h0000AA, 1, 1);
    hostRead(10'd3, 0, 0, 24'hAA0000, "R9 R5 partial write after clear");

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule